// File: doc/BRIEF.md
# Comma-Aligning Deserializer with Byte Clocks

This block sits behind a clock-and-data recovery stage. It takes one recovered serial bit on every cycle that carries a bit-clock enable, with the first bit of each character first on the line. The block keeps a sliding 10-bit window that moves one bit at a time. It cuts the stream into 10-bit characters and presents each finished character on a parallel word output. Two registered byte-clock levels go out alongside each word, so the downstream protocol logic can capture it.

While the alignment enable is high, the window is searched for the 7-bit comma prefix of the K28.5 control character on every bit. A comma that already lands on the current character boundary is passed through with the sync flag raised. A comma at any other of the ten bit offsets moves the boundary onto itself. The character that follows it is dropped, and the byte clocks stall while this happens. The byte clocks run either as one full-rate clock or as two complementary half-rate clocks. In half-rate mode the comma character is placed on the second clock.

Top module: `comma_align_deser`

## Requirements
- R1: While reset is held, word_out is 0, word_sync is 0, and bclk_a and bclk_b are both low.
- R2: The bits are numbered in arrival order counting only cycles with bit_en high, and the first bit received lands in word_out[0]. Each group of 10 such bits between boundaries appears on word_out in the cycle after its tenth bit. Cycles with bit_en low change no output except bclk_b, which R8 forces low in full-rate mode. After reset, the first boundary falls after the first 10 bits.
- R3: A comma is the seven bits 0,0,1,1,1,1,1 in arrival order, which is word_out[6:0] = 7'b1111100. The comma is recognised at any of the ten bit offsets from the current boundary. After a realignment, a later comma 10 characters-aligned is presented with word_sync high.
- R4: A comma whose first bit starts a character while align_en is high causes no realignment. That character is presented as usual, 10 bits after the previous one, with word_sync high. K28.5 is presented as word_out = 10'h17C.
- R5: A comma at any other offset while align_en is high moves the boundary so that the comma starts a character. Neither the comma nor the character after it is presented. The next word presented is the second character after the comma, 20 bit enables after the comma's tenth bit, with word_sync low.
- R6: word_sync changes only when a word is presented. It is high for exactly one word time after a comma-carrying word.
- R7: With align_en low, no comma is acted on. word_sync stays low and the boundary keeps its 10-bit cadence.
- R8: Full-rate mode (half_rate = 0): bclk_b is low. bclk_a rises only together with a presented word, and it falls on the fifth bit enable after the boundary. It does not fall in the cycle in which a realignment occurs.
- R9: Half-rate mode (half_rate = 1): each presented word leaves exactly one of bclk_a and bclk_b high, so each clock runs at half the word rate and the two are 180 degrees apart. A comma-carrying word always leaves bclk_b high and bclk_a low. Any other word swaps the two levels.
- R10: In half-rate mode, both byte clocks keep their levels in every cycle that does not present a word. This includes the whole realignment stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | High in a cycle that carries one serial bit |
| ser_bit | input | 1 | Serial data bit, qualified by bit_en |
| align_en | input | 1 | Enables comma search and boundary realignment |
| half_rate | input | 1 | 1 selects two half-rate byte clocks, 0 selects one full-rate clock |
| word_out | output | 10 | Aligned character, first received bit in bit 0 |
| word_sync | output | 1 | High for the word time of a comma-carrying character |
| bclk_a | output | 1 | First byte-clock level |
| bclk_b | output | 1 | Second byte-clock level (low in full-rate mode) |

## Verification
If the bit counter or the window is out of step by one bit, every later word on word_out comes out rotated. The first bad word shows within 10 bit enables, and bclk_a then rises at the wrong cycle. A drop flag that is lost or stuck shows in the next one or two character times. Either the dropped character appears on word_out, or a valid one goes missing, and the gap between byte-clock rises no longer equals 20 bit enables. A wrong half-rate phase shows at the very next comma, which must leave bclk_b high.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int unsigned CA_WORD_W = 10;
  localparam int unsigned CA_MARK_W = 7;
  // comma prefix, bit 0 is the first bit on the line
  localparam logic [CA_MARK_W-1:0] CA_MARK = 7'b1111100;
  typedef enum logic {PH_RUN = 1'b0, PH_DROP = 1'b1} ca_phase_e;
endpackage

// File: rtl/ca_rst_sync.sv
module ca_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_s = pipe_q[STAGES-1];
endmodule

// File: rtl/ca_shift_window.sv
module ca_shift_window #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_s,
  input  logic         bit_en,
  input  logic         ser_bit,
  output logic [W-1:0] win_next
);
  // history of the W-1 most recent bits, newest at the top
  logic [W-2:0] hist_q;
  logic [W-2:0] hist_d;

  assign win_next = {ser_bit, hist_q};

  always_comb begin
    hist_d = hist_q;
    if (bit_en) hist_d = win_next[W-1:1];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/ca_mark_match.sv
module ca_mark_match #(
  parameter int unsigned          MW   = 7,
  parameter logic [MW-1:0]        MARK = 7'b1111100
) (
  input  logic [MW-1:0] win_low,
  input  logic          align_en,
  output logic          hit
);
  logic [MW-1:0] eq;

  for (genvar i = 0; i < MW; i++) begin : g_cmp
    assign eq[i] = ~(win_low[i] ^ MARK[i]);
  end

  assign hit = align_en & (&eq);
endmodule

// File: rtl/ca_boundary.sv
module ca_boundary
  import ca_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic clk,
  input  logic rst_s,
  input  logic bit_en,
  input  logic hit,
  output logic emit,
  output logic realign,
  output logic on_edge,
  output logic mid
);
  localparam int unsigned          CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0]     LAST  = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0]     MIDC  = CNT_W'(W / 2 - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  ca_phase_e        ph_q;
  ca_phase_e        ph_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign on_edge = bit_en & at_last;
  assign realign = bit_en & hit & ~at_last;
  assign emit    = on_edge & ((ph_q == PH_RUN) | hit);
  assign mid     = bit_en & (cnt_q == MIDC) & ~realign;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (realign) begin
      cnt_d = '0;
      ph_d  = PH_DROP;
    end else if (on_edge) begin
      cnt_d = '0;
      ph_d  = PH_RUN;
    end else if (bit_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q <= '0;
      ph_q  <= PH_RUN;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/ca_byteclk.sv
module ca_byteclk (
  input  logic clk,
  input  logic rst_s,
  input  logic half_rate,
  input  logic emit,
  input  logic mark,
  input  logic mid,
  output logic clk_a,
  output logic clk_b
);
  logic a_q, a_d;
  logic b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (half_rate) begin
      if (emit) begin
        b_d = mark | ~b_q;
        a_d = ~b_d;
      end
    end else begin
      b_d = 1'b0;
      if (emit)     a_d = 1'b1;
      else if (mid) a_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign clk_a = a_q;
  assign clk_b = b_q;
endmodule

// File: rtl/comma_align_deser.sv
module comma_align_deser
  import ca_pkg::*;
#(
  parameter int unsigned          WORD_W = CA_WORD_W,
  parameter int unsigned          MARK_W = CA_MARK_W,
  parameter logic [MARK_W-1:0]    MARK   = CA_MARK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              ser_bit,
  input  logic              align_en,
  input  logic              half_rate,
  output logic [WORD_W-1:0] word_out,
  output logic              word_sync,
  output logic              bclk_a,
  output logic              bclk_b
);
  logic              rst_s;
  logic [WORD_W-1:0] win_w;
  logic              hit_w;
  logic              emit_w;
  logic              realign_w;
  logic              edge_w;
  logic              mid_w;

  logic [WORD_W-1:0] word_q, word_d;
  logic              sync_q, sync_d;

  ca_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  ca_shift_window #(.W(WORD_W)) u_win (
    .clk      (clk),
    .rst_s    (rst_s),
    .bit_en   (bit_en),
    .ser_bit  (ser_bit),
    .win_next (win_w)
  );

  ca_mark_match #(.MW(MARK_W), .MARK(MARK)) u_match (
    .win_low  (win_w[MARK_W-1:0]),
    .align_en (align_en),
    .hit      (hit_w)
  );

  ca_boundary #(.W(WORD_W)) u_bnd (
    .clk     (clk),
    .rst_s   (rst_s),
    .bit_en  (bit_en),
    .hit     (hit_w),
    .emit    (emit_w),
    .realign (realign_w),
    .on_edge (edge_w),
    .mid     (mid_w)
  );

  ca_byteclk u_bclk (
    .clk       (clk),
    .rst_s     (rst_s),
    .half_rate (half_rate),
    .emit      (emit_w),
    .mark      (hit_w),
    .mid       (mid_w),
    .clk_a     (bclk_a),
    .clk_b     (bclk_b)
  );

  always_comb begin
    word_d = word_q;
    sync_d = sync_q;
    if (emit_w) begin
      word_d = win_w;
      sync_d = hit_w;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      word_q <= '0;
      sync_q <= 1'b0;
    end else begin
      word_q <= word_d;
      sync_q <= sync_d;
    end
  end

  assign word_out  = word_q;
  assign word_sync = sync_q;
endmodule

// File: rtl/ca_checker.sv
module ca_checker #(
  parameter int unsigned W = 10
) (
  input logic         clk,
  input logic         rst_s,
  input logic         align_en,
  input logic         half_rate,
  input logic [W-1:0] word_out,
  input logic         word_sync,
  input logic         clk_a,
  input logic         clk_b,
  input logic         hit,
  input logic         emit,
  input logic         realign,
  input logic         on_edge
);
  // R7
  no_hunt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !align_en |-> !hit);

  // R4
  edge_comma_sync_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (hit && on_edge) |=> word_sync);

  // R5
  realign_no_word_chk: assert property (@(posedge clk) disable iff (!rst_s)
    realign |=> ($stable(word_out) && $stable(word_sync)));

  // R6
  sync_moves_with_word_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !emit |=> $stable(word_sync));

  // R8
  full_b_low_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !half_rate |=> !clk_b);

  // R8
  a_rise_with_word_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !emit |=> !$rose(clk_a));

  // R9
  half_split_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (half_rate && emit) |=> (clk_a != clk_b));

  // R9
  half_comma_b_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (half_rate && emit && hit) |=> (clk_b && !clk_a));

  // R10
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (half_rate && !emit) |=> ($stable(clk_a) && $stable(clk_b)));
endmodule

bind comma_align_deser ca_checker #(.W(WORD_W)) chk_i (
  .clk       (clk),
  .rst_s     (rst_s),
  .align_en  (align_en),
  .half_rate (half_rate),
  .word_out  (word_out),
  .word_sync (word_sync),
  .clk_a     (bclk_a),
  .clk_b     (bclk_b),
  .hit       (hit_w),
  .emit      (emit_w),
  .realign   (realign_w),
  .on_edge   (edge_w)
);

// File: tb/comma_align_deser_tb_top.sv
`timescale 1ns/1ps
module comma_align_deser_tb_top;
  localparam logic [9:0] KCH = 10'h17C;
  localparam logic [9:0] DA  = 10'h2AA;
  localparam logic [9:0] DB  = 10'h155;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       ser_bit = 1'b0;
  logic       align_en = 1'b0;
  logic       half_rate = 1'b0;
  logic [9:0] word_out;
  logic       word_sync;
  logic       bclk_a;
  logic       bclk_b;

  int checks = 0;
  int fails = 0;
  int gap = 0;
  int rises = 0;
  bit prev_a = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  comma_align_deser dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_bit(ser_bit),
    .align_en(align_en), .half_rate(half_rate), .word_out(word_out),
    .word_sync(word_sync), .bclk_a(bclk_a), .bclk_b(bclk_b)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         wq[$];
  int         m_cnt;
  bit         m_skip;
  logic [9:0] m_word;
  bit         m_sync, m_a, m_b;
  logic [9:0] mw;
  bit         m_hit, m_last, m_emit, m_re;
  int         m_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq.delete();
      m_cnt = 0; m_skip = 0; m_word = '0; m_sync = 0; m_a = 0; m_b = 0;
    end else begin
      if (bit_en) begin
        wq.push_back(ser_bit);
        if (wq.size() > 10) void'(wq.pop_front());
        for (int i = 0; i < 10; i++) begin
          m_idx = wq.size() - 10 + i;
          mw[i] = (m_idx >= 0) ? wq[m_idx] : 1'b0;
        end
        m_hit  = align_en && (mw[6:0] == 7'b1111100);
        m_last = (m_cnt == 9);
        m_re   = m_hit && !m_last;
        m_emit = m_last && (!m_skip || m_hit);
        if (m_emit) begin m_word = mw; m_sync = m_hit; end
        if (half_rate) begin
          if (m_emit) begin m_b = m_hit || !m_b; m_a = !m_b; end
        end else begin
          if (m_emit) m_a = 1;
          else if (m_cnt == 4 && !m_re) m_a = 0;
        end
        if (m_re) begin m_cnt = 0; m_skip = 1; end
        else if (m_last) begin m_cnt = 0; m_skip = 0; end
        else m_cnt++;
      end
      if (!half_rate) m_b = 0;
    end
  end

  // every-clock comparison and byte-clock rise monitor
  always @(negedge clk) begin
    if (rst_n) begin
      chk(word_out === m_word, "R2 word_out vs model", int'(word_out), int'(m_word));
      chk(word_sync === m_sync, "R6 word_sync vs model", int'(word_sync), int'(m_sync));
      chk(bclk_a === m_a, half_rate ? "R9 bclk_a vs model" : "R8 bclk_a vs model",
          int'(bclk_a), int'(m_a));
      chk(bclk_b === m_b, half_rate ? "R9 bclk_b vs model" : "R8 bclk_b vs model",
          int'(bclk_b), int'(m_b));
      if (bclk_a && !prev_a) rises++;
    end
    prev_a = bclk_a;
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_bit(input bit b);
    ser_bit = b;
    bit_en  = 1'b1;
    @(negedge clk);
    bit_en  = 1'b0;
    repeat (gap) @(negedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [9:0] w, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) send_bit(w[i]);
  endtask

  task automatic send_word(input logic [9:0] w);
    send_bits(w, 0, 9);
  endtask

  task automatic send_fill(input int n);
    for (int i = 0; i < n; i++) send_bit(((i % 2) == 0) ? 1'b1 : 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int   r0;
    logic [9:0] w0;
    bit   a0, b0;
    logic [15:0] lfsr;

    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(word_out == 10'h0, "R1 word_out in reset", int'(word_out), 0);
    chk(!word_sync, "R1 word_sync in reset", int'(word_sync), 0);
    chk(!bclk_a && !bclk_b, "R1 byte clocks in reset", int'({bclk_a, bclk_b}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;

    // R2 first word after reset, with idle gaps between bits
    gap = 1;
    send_word(10'h2A5);
    chk(word_out == 10'h2A5, "R2 first word LSB first", int'(word_out), 'h2A5);
    chk(bclk_a, "R8 bclk_a high with word", int'(bclk_a), 1);
    gap = 0;

    // R7 comma ignored while alignment is off
    align_en = 1'b0;
    send_fill(3);
    send_word(KCH);
    chk(!word_sync, "R7 no sync with align off", int'(word_sync), 0);
    send_bits(DA, 0, 6);
    chk(word_out == {DA[6:0], KCH[9:7]}, "R7 boundary kept", int'(word_out),
        int'({DA[6:0], KCH[9:7]}));
    chk(!word_sync, "R7 sync stays low", int'(word_sync), 0);
    send_bits(DA, 7, 9);
    send_bits(DA, 0, 6);

    // R4 comma on the boundary
    align_en = 1'b1;
    r0 = rises;
    send_word(KCH);
    chk(word_out == KCH, "R4 aligned comma presented", int'(word_out), int'(KCH));
    chk(word_sync, "R4 sync with aligned comma", int'(word_sync), 1);
    chk(rises == r0 + 1, "R4 one word in 10 bits", rises, r0 + 1);
    send_bits(DA, 0, 3);
    chk(bclk_a, "R8 bclk_a high for first 4 bits", int'(bclk_a), 1);
    send_bits(DA, 4, 4);
    chk(!bclk_a, "R8 bclk_a falls on 5th bit", int'(bclk_a), 0);
    chk(!bclk_b, "R8 bclk_b low in full rate", int'(bclk_b), 0);
    send_bits(DA, 5, 8);
    chk(word_sync, "R6 sync held for the word time", int'(word_sync), 1);
    send_bits(DA, 9, 9);
    chk(!word_sync, "R6 sync drops with next word", int'(word_sync), 0);

    // R5 straddling comma
    send_fill(3);
    send_word(KCH);
    r0 = rises;
    w0 = word_out;
    send_word(DA);
    chk(rises == r0, "R5 following char not presented", rises, r0);
    chk(word_out == w0, "R5 word held through drop", int'(word_out), int'(w0));
    send_word(DB);
    chk(rises == r0 + 1, "R5 second char presented at 20 bits", rises, r0 + 1);
    chk(word_out == DB, "R5 second char aligned", int'(word_out), int'(DB));
    chk(!word_sync, "R5 no sync on realign", int'(word_sync), 0);
    send_word(KCH);
    chk(word_sync && word_out == KCH, "R5 next comma aligned", int'(word_out), int'(KCH));

    // R3 comma found at every offset
    for (int off = 1; off < 10; off++) begin
      gap = off % 3;
      send_fill(off);
      send_word(KCH);
      send_word(DA);
      send_word(DB);
      chk(word_out == DB, $sformatf("R3 realign at offset %0d", off), int'(word_out), int'(DB));
      send_word(KCH);
      chk(word_sync && word_out == KCH, $sformatf("R3 comma aligned after offset %0d", off),
          int'(word_out), int'(KCH));
    end
    gap = 0;

    // R9 half-rate clocks
    half_rate = 1'b1;
    send_word(KCH);
    chk(bclk_b && !bclk_a, "R9 comma on second clock", int'({bclk_a, bclk_b}), 1);
    send_word(DA);
    chk(bclk_a && !bclk_b, "R9 swap on data word", int'({bclk_a, bclk_b}), 2);
    send_word(DB);
    chk(bclk_b && !bclk_a, "R9 swap again", int'({bclk_a, bclk_b}), 1);
    send_word(KCH);
    chk(bclk_b && !bclk_a, "R9 comma keeps second clock high", int'({bclk_a, bclk_b}), 1);
    send_word(DA);

    // R10 hold through realignment in half-rate mode
    send_fill(3);
    send_word(KCH);
    a0 = bclk_a;
    b0 = bclk_b;
    send_word(DA);
    chk(bclk_a == a0 && bclk_b == b0, "R10 clocks held during drop",
        int'({bclk_a, bclk_b}), int'({a0, b0}));
    send_word(DB);
    chk(bclk_a != a0 && bclk_a != bclk_b, "R10 clocks resume after drop",
        int'({bclk_a, bclk_b}), int'({!a0, a0}));
    send_word(KCH);
    chk(bclk_b && !bclk_a && word_sync, "R9 comma after realign", int'({bclk_a, bclk_b}), 1);

    // mixed traffic against the model
    half_rate = 1'b0;
    lfsr = 16'hACE1;
    for (int n = 0; n < 700; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gap = (lfsr[3:2] == 2'b11) ? 1 : 0;
      if (n == 350) half_rate = 1'b1;
      if (n == 200 || n == 550) align_en = ~align_en;
      if ((n % 47) == 0) send_word(KCH);
      else send_bit(lfsr[0]);
    end
    gap = 0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule